// File: doc/BRIEF.md
# Multichannel Supply Threshold Fault Monitor

This block supervises a set of supply rails through an external converter. It walks round-robin over the channels that are switched on for scanning. For each one it requests a conversion, waits for the converter's done strobe, and stores the 10-bit result in that channel's result register. In the same cycle it compares the result against that channel's upper and lower limits. Violations latch sticky per-channel fault flags, but only on channels whose fault generation is enabled. A per-channel direction select latches a separate early-warning indication.

Latched faults drive three kinds of action through masks. The general-purpose outputs each show a chosen OR of channel faults. A shutdown request is a level. A logger trigger is a single-cycle pulse. A margin mode silences the shutdown and logger actions while conversions and flags keep running. All limits, masks and modes are written through a simple register-write port; results are read back through a channel-indexed read port.

Top module: `supply_fault_monitor`

## Requirements
- R1: With `run_en` high, conversions visit the channels whose scan-enable bit (word at address 0x20, bit n = channel n) is 1, in ascending order with wrap-around, and skip the others. Just after reset the first channel visited is the lowest enabled one. With `run_en` low or no channel enabled, no new conversion is requested.
- R2: `conv_req` stays high with a stable `conv_chan` until `conv_done` is seen. The `conv_data` present on that cycle is stored in the result register of `conv_chan` and can be read back on `rd_result` by setting `rd_chan`.
- R3: An overvoltage violation occurs when the result is strictly greater than the channel's upper limit (address 0x00 + n, bits 9:0). A result equal to the limit is not a violation.
- R4: An undervoltage violation occurs when the result is strictly less than the channel's lower limit (address 0x10 + n, bits 9:0). A result equal to the limit is not a violation.
- R5: `fault_flags[n]` sets after a violating conversion only if the fault-enable bit n (address 0x21) is 1. Once set, it stays set until a write of 1 to bit n of address 0x26 or a reset. A set and a clear in the same cycle leave the flag set.
- R6: The early-warning direction bit n (address 0x22) selects the direction: 1 watches overvoltage and 0 watches undervoltage. A matching violation latches a sticky warning, independent of fault enable, that is cleared like the faults. `early_warn` is the OR of all latched warnings.
- R7: `gpio_out[g]` is high exactly when some latched fault is also set in the mask for output g (address 0x30 + g).
- R8: `shutdown_req` is high when a latched fault lies in the shutdown mask (address 0x23) and margin mode (address 0x25, bit 0) is off.
- R9: `log_trig` is a one-cycle pulse when the set of latched faults in the logger mask (address 0x24) goes from empty to non-empty. No pulse occurs while margin mode is on, and further faults give no pulse until that set has been emptied.
- R10: In margin mode, result registers and fault flags still update as normal.
- R11: During and after reset, all outputs are 0 and all limits, masks and modes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Enables scanning |
| conv_req | output | 1 | Conversion request, held until done |
| conv_chan | output | 4 | Channel being converted |
| conv_done | input | 1 | Converter done strobe |
| conv_data | input | 10 | Conversion result |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register write address |
| cfg_wdata | input | 12 | Register write data |
| rd_chan | input | 4 | Result read channel select |
| rd_result | output | 10 | Stored result of `rd_chan` |
| fault_flags | output | 12 | Sticky per-channel fault flags |
| early_warn | output | 1 | Any latched early warning |
| gpio_out | output | 4 | Masked fault combinations |
| shutdown_req | output | 1 | Shutdown request level |
| log_trig | output | 1 | Logger trigger pulse |

## Verification
Several properties are checked on every cycle. The request is held with a stable channel until done, and every started conversion targets an enabled channel. No request starts while scanning is off. Fault flags only appear after a done strobe and only on enabled channels, and they never drop without a clear write. Margin mode always silences shutdown and the logger, and the logger output never lasts two cycles. Other behaviour can only be shown by the directed scenarios: the actual visiting order, the stored result values, the strict limit boundaries, the early-warning direction, the GPIO combinations, and the single logger pulse per fault episode, including the case where margin mode hides the rising edge.

// File: rtl/smon_pkg.sv
package smon_pkg;
  localparam int ADDR_W = 6;

  localparam logic [1:0] GRP_OV   = 2'd0;
  localparam logic [1:0] GRP_UV   = 2'd1;
  localparam logic [1:0] GRP_CTL  = 2'd2;
  localparam logic [1:0] GRP_GPIO = 2'd3;

  localparam logic [3:0] CTL_CHAN_EN  = 4'd0;
  localparam logic [3:0] CTL_FAULT_EN = 4'd1;
  localparam logic [3:0] CTL_WARN_POL = 4'd2;
  localparam logic [3:0] CTL_SHDN     = 4'd3;
  localparam logic [3:0] CTL_LOG      = 4'd4;
  localparam logic [3:0] CTL_MODE     = 4'd5;
  localparam logic [3:0] CTL_CLEAR    = 4'd6;

  localparam logic [ADDR_W-1:0] ADDR_CLEAR = {GRP_CTL, CTL_CLEAR};

  typedef enum logic {
    SCAN_IDLE,
    SCAN_CONV
  } scan_state_e;
endpackage

// File: rtl/smon_cfg_regs.sv
module smon_cfg_regs
  import smon_pkg::*;
#(
  parameter int NCH   = 12,
  parameter int RES_W = 10,
  parameter int NGPIO = 4,
  parameter int WD_W  = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [ADDR_W-1:0]           cfg_addr,
  input  logic [WD_W-1:0]             cfg_wdata,
  output logic [NCH-1:0][RES_W-1:0]   ov_th,
  output logic [NCH-1:0][RES_W-1:0]   uv_th,
  output logic [NCH-1:0]              chan_en,
  output logic [NCH-1:0]              fault_en,
  output logic [NCH-1:0]              warn_pol,
  output logic [NCH-1:0]              shdn_mask,
  output logic [NCH-1:0]              log_mask,
  output logic [NGPIO-1:0][NCH-1:0]   gpio_mask,
  output logic                        margin,
  output logic [NCH-1:0]              clr_bits
);
  logic [1:0] grp;
  logic [3:0] idx;
  logic       ctl_we;

  logic [NCH-1:0][RES_W-1:0] ov_d, uv_d;
  logic [NCH-1:0]            chan_en_d, fault_en_d, warn_pol_d, shdn_d, log_d;
  logic [NGPIO-1:0][NCH-1:0] gpio_d;
  logic                      margin_d;

  assign grp    = cfg_addr[ADDR_W-1 -: 2];
  assign idx    = cfg_addr[3:0];
  assign ctl_we = cfg_we && (grp == GRP_CTL);

  assign clr_bits = (ctl_we && idx == CTL_CLEAR) ? cfg_wdata[NCH-1:0] : '0;

  always_comb begin
    ov_d       = ov_th;
    uv_d       = uv_th;
    chan_en_d  = chan_en;
    fault_en_d = fault_en;
    warn_pol_d = warn_pol;
    shdn_d     = shdn_mask;
    log_d      = log_mask;
    gpio_d     = gpio_mask;
    margin_d   = margin;
    for (int i = 0; i < NCH; i++) begin
      if (cfg_we && grp == GRP_OV && idx == 4'(i)) ov_d[i] = cfg_wdata[RES_W-1:0];
      if (cfg_we && grp == GRP_UV && idx == 4'(i)) uv_d[i] = cfg_wdata[RES_W-1:0];
    end
    for (int g = 0; g < NGPIO; g++) begin
      if (cfg_we && grp == GRP_GPIO && idx == 4'(g)) gpio_d[g] = cfg_wdata[NCH-1:0];
    end
    if (ctl_we) begin
      case (idx)
        CTL_CHAN_EN:  chan_en_d  = cfg_wdata[NCH-1:0];
        CTL_FAULT_EN: fault_en_d = cfg_wdata[NCH-1:0];
        CTL_WARN_POL: warn_pol_d = cfg_wdata[NCH-1:0];
        CTL_SHDN:     shdn_d     = cfg_wdata[NCH-1:0];
        CTL_LOG:      log_d      = cfg_wdata[NCH-1:0];
        CTL_MODE:     margin_d   = cfg_wdata[0];
        default:      ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_th     <= '0;
      uv_th     <= '0;
      chan_en   <= '0;
      fault_en  <= '0;
      warn_pol  <= '0;
      shdn_mask <= '0;
      log_mask  <= '0;
      gpio_mask <= '0;
      margin    <= 1'b0;
    end else if (cfg_we) begin
      ov_th     <= ov_d;
      uv_th     <= uv_d;
      chan_en   <= chan_en_d;
      fault_en  <= fault_en_d;
      warn_pol  <= warn_pol_d;
      shdn_mask <= shdn_d;
      log_mask  <= log_d;
      gpio_mask <= gpio_d;
      margin    <= margin_d;
    end
  end
endmodule

// File: rtl/smon_scan.sv
module smon_scan
  import smon_pkg::*;
#(
  parameter int NCH  = 12,
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_en,
  input  logic [NCH-1:0]  chan_en,
  input  logic            conv_done,
  output logic            conv_req,
  output logic [CH_W-1:0] conv_chan,
  output logic            cap_en
);
  scan_state_e     st_q, st_d;
  logic [CH_W-1:0] ch_q, ch_d;
  logic [CH_W-1:0] pick_ch;
  logic            pick_ok;

  // Round-robin search: first enabled channel after the current one.
  always_comb begin
    pick_ok = 1'b0;
    pick_ch = ch_q;
    for (int k = 1; k <= NCH; k++) begin
      int pos;
      pos = (int'(ch_q) + k) % NCH;
      if (!pick_ok && chan_en[pos]) begin
        pick_ok = 1'b1;
        pick_ch = CH_W'(pos);
      end
    end
  end

  always_comb begin
    st_d = st_q;
    ch_d = ch_q;
    case (st_q)
      SCAN_IDLE: if (run_en && pick_ok) begin
        st_d = SCAN_CONV;
        ch_d = pick_ch;
      end
      SCAN_CONV: if (conv_done) st_d = SCAN_IDLE;
      default:   st_d = SCAN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SCAN_IDLE;
      ch_q <= CH_W'(NCH - 1);
    end else begin
      st_q <= st_d;
      ch_q <= ch_d;
    end
  end

  assign conv_req  = (st_q == SCAN_CONV);
  assign conv_chan = ch_q;
  assign cap_en    = conv_req && conv_done;
endmodule

// File: rtl/smon_eval.sv
module smon_eval #(
  parameter int NCH   = 12,
  parameter int RES_W = 10,
  parameter int CH_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cap_en,
  input  logic [CH_W-1:0]           cap_chan,
  input  logic [RES_W-1:0]          conv_data,
  input  logic [NCH-1:0][RES_W-1:0] ov_th,
  input  logic [NCH-1:0][RES_W-1:0] uv_th,
  input  logic [NCH-1:0]            fault_en,
  input  logic [NCH-1:0]            warn_pol,
  input  logic [NCH-1:0]            clr_bits,
  input  logic [CH_W-1:0]           rd_chan,
  output logic [RES_W-1:0]          rd_result,
  output logic [NCH-1:0]            fault_q,
  output logic [NCH-1:0]            warn_q
);
  localparam logic [CH_W:0] CH_CNT = (CH_W+1)'(NCH);

  logic [NCH-1:0][RES_W-1:0] res_q, res_d;
  logic [NCH-1:0]            fault_d, warn_d, fault_set, warn_set;
  logic                      ov_hit, uv_hit;

  assign ov_hit = conv_data > ov_th[cap_chan];
  assign uv_hit = conv_data < uv_th[cap_chan];

  always_comb begin
    res_d     = res_q;
    fault_set = '0;
    warn_set  = '0;
    for (int i = 0; i < NCH; i++) begin
      if (cap_en && cap_chan == CH_W'(i)) begin
        res_d[i]     = conv_data;
        fault_set[i] = fault_en[i] && (ov_hit || uv_hit);
        warn_set[i]  = warn_pol[i] ? ov_hit : uv_hit;
      end
    end
    fault_d = (fault_q & ~clr_bits) | fault_set;
    warn_d  = (warn_q & ~clr_bits) | warn_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (cap_en) begin
      res_q <= res_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= '0;
      warn_q  <= '0;
    end else begin
      fault_q <= fault_d;
      warn_q  <= warn_d;
    end
  end

  assign rd_result = ({1'b0, rd_chan} < CH_CNT) ? res_q[rd_chan] : '0;
endmodule

// File: rtl/supply_fault_monitor.sv
module supply_fault_monitor
  import smon_pkg::*;
#(
  parameter int NCH   = 12,
  parameter int RES_W = 10,
  parameter int NGPIO = 4,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int WD_W = (NCH > RES_W) ? NCH : RES_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  output logic              conv_req,
  output logic [CH_W-1:0]   conv_chan,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [WD_W-1:0]   cfg_wdata,
  input  logic [CH_W-1:0]   rd_chan,
  output logic [RES_W-1:0]  rd_result,
  output logic [NCH-1:0]    fault_flags,
  output logic              early_warn,
  output logic [NGPIO-1:0]  gpio_out,
  output logic              shutdown_req,
  output logic              log_trig
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NCH-1:0][RES_W-1:0] ov_th, uv_th;
  logic [NCH-1:0]            chan_en, fault_en, warn_pol, shdn_mask, log_mask, clr_bits;
  logic [NGPIO-1:0][NCH-1:0] gpio_mask;
  logic                      margin;
  logic                      cap_en;
  logic [NCH-1:0]            warn_q;

  smon_cfg_regs #(.NCH(NCH), .RES_W(RES_W), .NGPIO(NGPIO), .WD_W(WD_W)) u_cfg (
    .clk(clk), .rst_n(rst_int_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ov_th(ov_th), .uv_th(uv_th), .chan_en(chan_en),
    .fault_en(fault_en), .warn_pol(warn_pol), .shdn_mask(shdn_mask),
    .log_mask(log_mask), .gpio_mask(gpio_mask), .margin(margin),
    .clr_bits(clr_bits)
  );

  smon_scan #(.NCH(NCH), .CH_W(CH_W)) u_scan (
    .clk(clk), .rst_n(rst_int_n), .run_en(run_en), .chan_en(chan_en),
    .conv_done(conv_done), .conv_req(conv_req), .conv_chan(conv_chan),
    .cap_en(cap_en)
  );

  smon_eval #(.NCH(NCH), .RES_W(RES_W), .CH_W(CH_W)) u_eval (
    .clk(clk), .rst_n(rst_int_n), .cap_en(cap_en), .cap_chan(conv_chan),
    .conv_data(conv_data), .ov_th(ov_th), .uv_th(uv_th), .fault_en(fault_en),
    .warn_pol(warn_pol), .clr_bits(clr_bits), .rd_chan(rd_chan),
    .rd_result(rd_result), .fault_q(fault_flags), .warn_q(warn_q)
  );

  assign early_warn = |warn_q;

  for (genvar g = 0; g < NGPIO; g++) begin : g_gpio
    assign gpio_out[g] = |(fault_flags & gpio_mask[g]);
  end

  assign shutdown_req = (|(fault_flags & shdn_mask)) && !margin;

  // Logger trigger on the rising edge of the masked-fault aggregate.
  logic log_any, log_any_q;
  assign log_any = |(fault_flags & log_mask);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) log_any_q <= 1'b0;
    else            log_any_q <= log_any;
  end

  assign log_trig = log_any && !log_any_q && !margin;
endmodule

// File: rtl/smon_chk.sv
module smon_chk
  import smon_pkg::*;
#(
  parameter int NCH  = 12,
  parameter int CH_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_en,
  input logic              conv_req,
  input logic [CH_W-1:0]   conv_chan,
  input logic              conv_done,
  input logic [NCH-1:0]    chan_en,
  input logic [NCH-1:0]    fault_en,
  input logic [NCH-1:0]    fault_flags,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic              margin,
  input logic              shutdown_req,
  input logic              log_trig
);
  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && !conv_done |=> conv_req && $stable(conv_chan));

  a_r1_pick_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_req) |-> ($past(chan_en) & (NCH'(1) << conv_chan)) != '0);

  a_r1_no_start_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en && !conv_req |=> !conv_req);

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_addr == ADDR_CLEAR) |=> (fault_flags & $past(fault_flags)) == $past(fault_flags));

  a_r5_set_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> (fault_flags & ~$past(fault_flags)) == '0);

  a_r5_set_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> (fault_flags & ~$past(fault_flags) & ~$past(fault_en)) == '0);

  a_r8_margin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    margin |-> !shutdown_req && !log_trig);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    log_trig |=> !log_trig);
endmodule

bind supply_fault_monitor smon_chk #(.NCH(NCH), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .conv_req(conv_req),
  .conv_chan(conv_chan), .conv_done(conv_done), .chan_en(chan_en),
  .fault_en(fault_en), .fault_flags(fault_flags), .cfg_we(cfg_we),
  .cfg_addr(cfg_addr), .margin(margin), .shutdown_req(shutdown_req),
  .log_trig(log_trig)
);

// File: tb/supply_fault_monitor_tb.sv
module supply_fault_monitor_tb;
  localparam int NCH = 12;
  localparam int RES_W = 10;
  localparam int NGPIO = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n, run_en, conv_req, conv_done, cfg_we;
  logic [3:0]       conv_chan, rd_chan;
  logic [RES_W-1:0] conv_data, rd_result;
  logic [5:0]       cfg_addr;
  logic [11:0]      cfg_wdata;
  logic [NCH-1:0]   fault_flags;
  logic             early_warn, shutdown_req, log_trig;
  logic [NGPIO-1:0] gpio_out;

  supply_fault_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .conv_req(conv_req),
    .conv_chan(conv_chan), .conv_done(conv_done), .conv_data(conv_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .rd_chan(rd_chan), .rd_result(rd_result), .fault_flags(fault_flags),
    .early_warn(early_warn), .gpio_out(gpio_out),
    .shutdown_req(shutdown_req), .log_trig(log_trig)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [RES_W-1:0] adc_v [NCH];
  int chan_hist [32];
  int conv_cnt = 0;
  int log_cnt = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Converter model: answers each request after a varying latency.
  initial begin
    conv_done = 1'b0;
    conv_data = '0;
    forever begin
      @(negedge clk);
      if (conv_req) begin
        repeat (1 + conv_cnt % 3) @(negedge clk);
        conv_data = adc_v[conv_chan];
        if (conv_cnt < 32) chan_hist[conv_cnt] = int'(conv_chan);
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        conv_cnt++;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (log_trig) log_cnt++;
  end

  task automatic cfg_write(logic [5:0] a, logic [11:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_all();
    cfg_write(6'h26, 12'hFFF);
  endtask

  task automatic run_one(int ch, int val);
    int start;
    cfg_write(6'h20, 12'(1 << ch));
    adc_v[ch] = RES_W'(val);
    start = conv_cnt;
    run_en = 1'b1;
    wait (conv_cnt == start + 1);
    run_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11", "conv_req in reset", int'(conv_req), 0);
    chk("R11", "fault_flags in reset", int'(fault_flags), 0);
    chk("R11", "gpio in reset", int'(gpio_out), 0);
    chk("R11", "shutdown/log/warn in reset", int'({shutdown_req, log_trig, early_warn}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11", "fault_flags after reset", int'(fault_flags), 0);
  endtask

  task automatic t_scan_order();
    int exp_seq [5] = '{0, 3, 6, 9, 11};
    for (int i = 0; i < NCH; i++) adc_v[i] = RES_W'(100 + 37 * i);
    cfg_write(6'h20, 12'hA49);
    run_en = 1'b1;
    wait (conv_cnt == 10);
    run_en = 1'b0;
    for (int i = 0; i < 10; i++) chk("R1", $sformatf("visit %0d", i), chan_hist[i], exp_seq[i % 5]);
    repeat (5) @(negedge clk);
    chk("R1", "no request with run_en low", int'(conv_req), 0);
    for (int i = 0; i < 5; i++) begin
      rd_chan = 4'(exp_seq[i]);
      @(negedge clk);
      chk("R2", $sformatf("result ch%0d", exp_seq[i]), int'(rd_result), 100 + 37 * exp_seq[i]);
    end
    rd_chan = 4'd1;
    @(negedge clk);
    chk("R2", "unscanned ch1 result", int'(rd_result), 0);
    cfg_write(6'h20, 12'h000);
    run_en = 1'b1;
    repeat (8) @(negedge clk);
    chk("R1", "no request with empty mask", int'(conv_req), 0);
    run_en = 1'b0;
  endtask

  task automatic t_limits();
    cfg_write(6'h02, 12'd500);
    cfg_write(6'h12, 12'd100);
    cfg_write(6'h21, 12'h004);
    run_one(2, 500);
    chk("R3", "equal to upper limit", int'(fault_flags), 0);
    run_one(2, 501);
    chk("R3", "above upper limit", int'(fault_flags), 4);
    clear_all();
    chk("R5", "cleared by write", int'(fault_flags), 0);
    run_one(2, 100);
    chk("R4", "equal to lower limit", int'(fault_flags), 0);
    run_one(2, 99);
    chk("R4", "below lower limit", int'(fault_flags), 4);
    run_one(2, 300);
    chk("R5", "sticky after good sample", int'(fault_flags), 4);
    clear_all();
    cfg_write(6'h21, 12'h000);
    run_one(2, 900);
    chk("R5", "violation with fault disabled", int'(fault_flags), 0);
    rd_chan = 4'd2;
    @(negedge clk);
    chk("R2", "ch2 result 900", int'(rd_result), 900);
  endtask

  task automatic t_warn();
    clear_all();
    cfg_write(6'h22, 12'h004);
    run_one(2, 50);
    chk("R6", "OV-direction ignores UV", int'(early_warn), 0);
    run_one(2, 700);
    chk("R6", "OV-direction warns on OV", int'(early_warn), 1);
    clear_all();
    cfg_write(6'h22, 12'h000);
    run_one(2, 700);
    chk("R6", "UV-direction ignores OV", int'(early_warn), 0);
    run_one(2, 50);
    chk("R6", "UV-direction warns on UV", int'(early_warn), 1);
    clear_all();
    chk("R6", "warning cleared", int'(early_warn), 0);
  endtask

  task automatic t_gpio();
    cfg_write(6'h01, 12'd500);
    cfg_write(6'h04, 12'd500);
    cfg_write(6'h21, 12'h012);
    cfg_write(6'h30, 12'h002);
    cfg_write(6'h31, 12'h030);
    cfg_write(6'h32, 12'h080);
    cfg_write(6'h33, 12'h000);
    run_one(1, 600);
    chk("R7", "gpio after ch1 fault", int'(gpio_out), 1);
    run_one(4, 600);
    chk("R7", "gpio after ch4 fault", int'(gpio_out), 3);
    clear_all();
    chk("R7", "gpio after clear", int'(gpio_out), 0);
  endtask

  task automatic t_actions();
    cfg_write(6'h23, 12'h002);
    cfg_write(6'h24, 12'h002);
    log_cnt = 0;
    run_one(4, 600);
    chk("R8", "unmasked fault no shutdown", int'(shutdown_req), 0);
    chk("R9", "unmasked fault no log", log_cnt, 0);
    run_one(1, 600);
    chk("R8", "masked fault shutdown", int'(shutdown_req), 1);
    chk("R9", "first masked fault logs once", log_cnt, 1);
    run_one(1, 700);
    chk("R9", "repeat fault no new log", log_cnt, 1);
    cfg_write(6'h25, 12'h001);
    chk("R8", "margin hides shutdown", int'(shutdown_req), 0);
    clear_all();
    run_one(1, 800);
    chk("R10", "margin keeps fault flag", int'(fault_flags), 2);
    rd_chan = 4'd1;
    @(negedge clk);
    chk("R10", "margin keeps result", int'(rd_result), 800);
    chk("R9", "margin hides log", log_cnt, 1);
    cfg_write(6'h25, 12'h000);
    chk("R8", "shutdown after margin off", int'(shutdown_req), 1);
    chk("R9", "no late log after margin", log_cnt, 1);
    clear_all();
    run_one(1, 800);
    chk("R9", "new episode logs", log_cnt, 2);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    run_en = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; rd_chan = '0;
    for (int i = 0; i < NCH; i++) adc_v[i] = '0;
    t_reset();
    t_scan_order();
    t_limits();
    t_warn();
    t_gpio();
    t_actions();
    finished = 1;
    summary();
    $finish;
  end
endmodule